// File: doc/BRIEF.md
# Floating-Point Condition Predicate Unit

This block decides the outcome of conditional floating-point instructions. Each request carries a 6-bit condition code and the floating-point status word. The unit takes the negative, zero and not-a-number flags out of that word. It evaluates one of sixteen unordered-aware predicates and applies the result to one of four actions. The actions are a conditional branch, a decrement-and-branch loop step on a 16-bit counter, a set-byte write, and a trap request. A code with its top bit set is not a legal condition. Such a request is flagged and causes no action.

The block sits next to an integer pipeline. That pipeline supplies the counter register, the destination register, the program counter and the displacement, and it consumes the registered results. All results appear one clock after the request strobe. Write enables, branch and trap requests are single-cycle pulses.

Top module: `fcc_unit`

## Requirements
- R1: While reset is high, and on the first edge after it, every output is zero.
- R2: `done_o` is high for exactly the one cycle following a cycle with `valid_i` high, and low otherwise.
- R3: The predicate reads only status bit 27 (N), bit 26 (Z) and bit 24 (NaN). Bit 25 and all other bits have no effect.
- R4: For code c with c[5:4]=00, `pred_o` is given by c[3:0] as follows. 0: false. 1: Z. 2: not(NaN or Z or N). 3: Z or not(NaN or N). 4: N and not(NaN or Z). 5: Z or (N and not NaN). 6: not(NaN or Z). 7: not NaN. 8: NaN. 9: NaN or Z. A: NaN or not(N or Z). B: NaN or Z or not N. C: NaN or (N and not Z). D: NaN or Z or N. E: not Z. F: true.
- R5: Codes 0x10 to 0x1F give the same predicate as the code 0x10 lower.
- R6: A code above 0x1F pulses `illegal_o` with `done_o`. It forces `pred_o` to 0 and suppresses `branch_o`, `count_we_o`, `set_we_o` and `trap_req_o`. This priority holds over every action.
- R7: Action 1 (loop) with a false predicate writes `count_o` = `count_i` with only bits [15:0] decremented modulo 2^16, and pulses `count_we_o`. It pulses `branch_o` exactly when the new low half equals 0xFFFF.
- R8: Action 1 with a true predicate pulses neither `count_we_o` nor `branch_o`.
- R9: Action 2 (set) pulses `set_we_o`. It outputs `set_o` = `dest_i` with bits [7:0] replaced by 0xFF when the predicate is true and by 0x00 when it is false.
- R10: Action 3 (trap) pulses `trap_req_o` exactly when the predicate is true.
- R11: Action 0 (branch) pulses `branch_o` exactly when the predicate is true. `target_o` is `pc_i` + `disp_i` sign-extended from bits [15:0] when `long_disp_i` is 0, and `pc_i` + `disp_i` when it is 1. The loop action uses the same target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request strobe |
| cond_i | input | 6 | Condition code |
| action_i | input | 2 | 0 branch, 1 loop, 2 set, 3 trap |
| fpsr_i | input | 32 | Floating-point status word |
| count_i | input | 32 | Loop counter register value |
| dest_i | input | 32 | Set-byte destination register value |
| pc_i | input | 32 | Branch base address |
| disp_i | input | 32 | Branch displacement |
| long_disp_i | input | 1 | Use all 32 displacement bits |
| done_o | output | 1 | Result valid pulse |
| pred_o | output | 1 | Predicate result |
| illegal_o | output | 1 | Illegal condition pulse |
| branch_o | output | 1 | Branch taken pulse |
| target_o | output | 32 | Branch target |
| count_we_o | output | 1 | Counter write pulse |
| count_o | output | 32 | New counter register value |
| set_we_o | output | 1 | Destination write pulse |
| set_o | output | 32 | New destination register value |
| trap_req_o | output | 1 | Trap request pulse |

## Verification
The hardest situation to reach is the loop branch. It needs a false predicate and a counter whose low half is exactly zero, so that the decrement wraps to 0xFFFF. The upper half must survive that wrap unchanged. The bench builds this case on purpose: it uses code 0x00, which is always false, with a counter of 0x1234_0000. It then repeats the case with a code that is false only for particular flag settings, and it contrasts both with non-wrapping counts and with true predicates. The full sweep of all 64 codes against all 16 patterns of the four status flag bits also places junk in the ignored status bits.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam int STAT_W  = 32;
  localparam int N_POS   = 27;
  localparam int Z_POS   = 26;
  localparam int NAN_POS = 24;

  typedef enum logic [1:0] {
    ACT_BRANCH = 2'd0,
    ACT_LOOP   = 2'd1,
    ACT_SETB   = 2'd2,
    ACT_TRAP   = 2'd3
  } fcc_act_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic nan;
  } fcc_flags_t;
endpackage

// File: rtl/fcc_predicate.sv
module fcc_predicate
  import fcc_pkg::*;
#(
  parameter int COND_W = 6
) (
  input  logic [COND_W-1:0] cond,
  input  fcc_flags_t        flags,
  output logic              pred,
  output logic              illegal
);
  localparam int SEL_W = 4;

  logic [15:0] fn;
  logic n, z, u;

  assign n = flags.neg;
  assign z = flags.zero;
  assign u = flags.nan;

  always_comb begin
    fn[0]  = 1'b0;
    fn[1]  = z;
    fn[2]  = ~(u | z | n);
    fn[3]  = z | ~(u | n);
    fn[4]  = n & ~(u | z);
    fn[5]  = z | (n & ~u);
    fn[6]  = ~(u | z);
    fn[7]  = ~u;
    fn[8]  = u;
    fn[9]  = u | z;
    fn[10] = u | ~(n | z);
    fn[11] = u | z | ~n;
    fn[12] = u | (n & ~z);
    fn[13] = u | z | n;
    fn[14] = ~z;
    fn[15] = 1'b1;
  end

  // codes with any bit above bit 4 set are outside the legal range
  assign illegal = |cond[COND_W-1:SEL_W+1];
  assign pred    = fn[cond[SEL_W-1:0]] & ~illegal;
endmodule

// File: rtl/fcc_target.sv
module fcc_target #(
  parameter int DATA_W = 32,
  parameter int DISP_W = 16
) (
  input  logic [DATA_W-1:0] pc,
  input  logic [DATA_W-1:0] disp,
  input  logic              long_disp,
  output logic [DATA_W-1:0] target
);
  logic [DATA_W-1:0] short_ext;

  generate
    if (DISP_W < DATA_W) begin : g_ext
      assign short_ext = {{(DATA_W-DISP_W){disp[DISP_W-1]}}, disp[DISP_W-1:0]};
    end else begin : g_full
      assign short_ext = disp;
    end
  endgenerate

  assign target = pc + (long_disp ? disp : short_ext);
endmodule

// File: rtl/fcc_action.sv
module fcc_action
  import fcc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  fcc_act_e          act,
  input  logic              pred,
  input  logic              illegal,
  input  logic [DATA_W-1:0] count_in,
  input  logic [DATA_W-1:0] dest_in,
  output logic              branch,
  output logic              count_we,
  output logic [DATA_W-1:0] count_nxt,
  output logic              set_we,
  output logic [DATA_W-1:0] set_nxt,
  output logic              trap
);
  localparam logic [CNT_W-1:0] CNT_WRAP = '1;

  logic [CNT_W-1:0] low_dec;

  assign low_dec = count_in[CNT_W-1:0] - 1'b1;

  always_comb begin
    count_nxt = count_in;
    count_nxt[CNT_W-1:0] = low_dec;
    set_nxt = dest_in;
    set_nxt[BYTE_W-1:0] = {BYTE_W{pred}};
    branch   = 1'b0;
    count_we = 1'b0;
    set_we   = 1'b0;
    trap     = 1'b0;
    if (!illegal) begin
      unique case (act)
        ACT_BRANCH: branch = pred;
        ACT_LOOP: begin
          count_we = ~pred;
          branch   = ~pred & (low_dec == CNT_WRAP);
        end
        ACT_SETB: set_we = 1'b1;
        ACT_TRAP: trap   = pred;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fcc_unit.sv
module fcc_unit
  import fcc_pkg::*;
#(
  parameter int COND_W = 6,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic [1:0]        action_i,
  input  logic [STAT_W-1:0] fpsr_i,
  input  logic [DATA_W-1:0] count_i,
  input  logic [DATA_W-1:0] dest_i,
  input  logic [DATA_W-1:0] pc_i,
  input  logic [DATA_W-1:0] disp_i,
  input  logic              long_disp_i,
  output logic              done_o,
  output logic              pred_o,
  output logic              illegal_o,
  output logic              branch_o,
  output logic [DATA_W-1:0] target_o,
  output logic              count_we_o,
  output logic [DATA_W-1:0] count_o,
  output logic              set_we_o,
  output logic [DATA_W-1:0] set_o,
  output logic              trap_req_o
);
  fcc_flags_t        flags;
  logic              pred_c, ill_c, br_c, cwe_c, swe_c, trap_c;
  logic [DATA_W-1:0] tgt_c, cnt_c, set_c;

  assign flags.neg  = fpsr_i[N_POS];
  assign flags.zero = fpsr_i[Z_POS];
  assign flags.nan  = fpsr_i[NAN_POS];

  fcc_predicate #(.COND_W(COND_W)) u_pred (
    .cond(cond_i), .flags(flags), .pred(pred_c), .illegal(ill_c)
  );

  fcc_target #(.DATA_W(DATA_W), .DISP_W(DISP_W)) u_tgt (
    .pc(pc_i), .disp(disp_i), .long_disp(long_disp_i), .target(tgt_c)
  );

  fcc_action #(.DATA_W(DATA_W), .CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_act (
    .act(fcc_act_e'(action_i)), .pred(pred_c), .illegal(ill_c),
    .count_in(count_i), .dest_in(dest_i),
    .branch(br_c), .count_we(cwe_c), .count_nxt(cnt_c),
    .set_we(swe_c), .set_nxt(set_c), .trap(trap_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o     <= 1'b0;
      pred_o     <= 1'b0;
      illegal_o  <= 1'b0;
      branch_o   <= 1'b0;
      target_o   <= '0;
      count_we_o <= 1'b0;
      count_o    <= '0;
      set_we_o   <= 1'b0;
      set_o      <= '0;
      trap_req_o <= 1'b0;
    end else begin
      done_o     <= valid_i;
      illegal_o  <= valid_i & ill_c;
      branch_o   <= valid_i & br_c;
      count_we_o <= valid_i & cwe_c;
      set_we_o   <= valid_i & swe_c;
      trap_req_o <= valid_i & trap_c;
      if (valid_i) begin
        pred_o   <= pred_c;
        target_o <= tgt_c;
        count_o  <= cnt_c;
        set_o    <= set_c;
      end
    end
  end
endmodule

// File: rtl/fcc_unit_chk.sv
module fcc_unit_chk #(
  parameter int COND_W = 6,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              valid_i,
  input logic [COND_W-1:0] cond_i,
  input logic [DATA_W-1:0] count_i,
  input logic [DATA_W-1:0] dest_i,
  input logic              done_o,
  input logic              pred_o,
  input logic              illegal_o,
  input logic              branch_o,
  input logic              count_we_o,
  input logic [DATA_W-1:0] count_o,
  input logic              set_we_o,
  input logic [DATA_W-1:0] set_o,
  input logic              trap_req_o
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> !done_o && !branch_o && !trap_req_o && !count_we_o && !set_we_o);

  assert_done_follows_valid_R2: assert property (@(posedge clk) disable iff (rst)
    $past(valid_i) == done_o);

  assert_illegal_blocks_actions_R6: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> done_o && !pred_o && !branch_o && !count_we_o && !set_we_o && !trap_req_o);

  assert_illegal_code_R6: assert property (@(posedge clk) disable iff (rst)
    (valid_i && (cond_i >= COND_W'(32))) |=> illegal_o);

  assert_loop_decrement_R7: assert property (@(posedge clk) disable iff (rst)
    count_we_o |-> (count_o[CNT_W-1:0] == CNT_W'($past(count_i[CNT_W-1:0]) - 1'b1))
                && (count_o[DATA_W-1:CNT_W] == $past(count_i[DATA_W-1:CNT_W])));

  assert_loop_only_when_false_R8: assert property (@(posedge clk) disable iff (rst)
    count_we_o |-> !pred_o);

  assert_set_byte_R9: assert property (@(posedge clk) disable iff (rst)
    set_we_o |-> (set_o[BYTE_W-1:0] == {BYTE_W{pred_o}})
              && (set_o[DATA_W-1:BYTE_W] == $past(dest_i[DATA_W-1:BYTE_W])));

  assert_trap_needs_true_R10: assert property (@(posedge clk) disable iff (rst)
    trap_req_o |-> pred_o && done_o);

  assert_pulses_one_hot_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({trap_req_o, set_we_o, count_we_o && !branch_o, branch_o}));
endmodule

bind fcc_unit fcc_unit_chk #(
  .COND_W(COND_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .BYTE_W(BYTE_W)
) u_chk (
  .clk(clk), .rst(rst), .valid_i(valid_i), .cond_i(cond_i),
  .count_i(count_i), .dest_i(dest_i), .done_o(done_o), .pred_o(pred_o),
  .illegal_o(illegal_o), .branch_o(branch_o), .count_we_o(count_we_o),
  .count_o(count_o), .set_we_o(set_we_o), .set_o(set_o), .trap_req_o(trap_req_o)
);

// File: tb/test_fcc_unit.sv
`timescale 1ns/1ps
module test_fcc_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i;
  logic [5:0]  cond_i;
  logic [1:0]  action_i;
  logic [31:0] fpsr_i, count_i, dest_i, pc_i, disp_i;
  logic        long_disp_i;
  logic        done_o, pred_o, illegal_o, branch_o, count_we_o, set_we_o, trap_req_o;
  logic [31:0] target_o, count_o, set_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  fcc_unit i_fcc_unit (
    .clk(clk), .rst(rst), .valid_i(valid_i), .cond_i(cond_i), .action_i(action_i),
    .fpsr_i(fpsr_i), .count_i(count_i), .dest_i(dest_i), .pc_i(pc_i), .disp_i(disp_i),
    .long_disp_i(long_disp_i), .done_o(done_o), .pred_o(pred_o), .illegal_o(illegal_o),
    .branch_o(branch_o), .target_o(target_o), .count_we_o(count_we_o), .count_o(count_o),
    .set_we_o(set_we_o), .set_o(set_o), .trap_req_o(trap_req_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // predicate model written from the requirement table
  function automatic logic model(input logic [5:0] c, input logic [31:0] s);
    logic n, z, u, r;
    n = s[27]; z = s[26]; u = s[24];
    case (c[3:0])
      4'h0: r = 0;
      4'h1: r = z;
      4'h2: r = !u && !z && !n;
      4'h3: r = z || (!u && !n);
      4'h4: r = n && !u && !z;
      4'h5: r = z || (n && !u);
      4'h6: r = !u && !z;
      4'h7: r = !u;
      4'h8: r = u;
      4'h9: r = u || z;
      4'hA: r = u || (!n && !z);
      4'hB: r = u || z || !n;
      4'hC: r = u || (n && !z);
      4'hD: r = u || z || n;
      4'hE: r = !z;
      default: r = 1;
    endcase
    return (c > 6'h1F) ? 1'b0 : r;
  endfunction

  task automatic issue(input logic [1:0] a, input logic [5:0] c, input logic [31:0] s,
                       input logic [31:0] cnt, input logic [31:0] dst,
                       input logic [31:0] pc, input logic [31:0] dsp, input logic lng);
    @(negedge clk);
    valid_i = 1; action_i = a; cond_i = c; fpsr_i = s; count_i = cnt;
    dest_i = dst; pc_i = pc; disp_i = dsp; long_disp_i = lng;
    @(negedge clk);
    valid_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R2 watchdog actual=hang expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1; valid_i = 0; cond_i = 0; action_i = 0; fpsr_i = 0; count_i = 0;
    dest_i = 0; pc_i = 0; disp_i = 0; long_disp_i = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {done_o, pred_o, illegal_o, branch_o, count_we_o, set_we_o, trap_req_o}, 0);
    check("R1 count", count_o, 0);
    check("R1 set", set_o, 0);
    rst = 0;
    @(negedge clk);
    check("R2 idle", done_o, 0);

    // sweep all codes and all status flag patterns; junk in ignored bits (R3)
    for (int c = 0; c < 64; c++) begin
      for (int f = 0; f < 16; f++) begin
        logic [31:0] s;
        logic e;
        string tag;
        s = 32'h3052_8C71 | (32'(f) << 24);
        e = model(6'(c), s);
        tag = (c > 31) ? "R6" : (c > 15) ? "R5" : "R4 R3";
        issue(2'd3, 6'(c), s, 0, 0, 0, 0, 0);
        check("R2 done", done_o, 1);
        check(tag, pred_o, e);
        check("R6 illegal", illegal_o, c > 31);
        check("R10 trap", trap_req_o, e);
        issue(2'd2, 6'(c), s, 0, 32'hCAFE_BE5A, 0, 0, 0);
        check("R9 set", set_o, (c > 31) ? set_o : {24'hCAFEBE, {8{e}}});
        check("R9 set_we", set_we_o, c < 32);
        check("R6 no branch", branch_o, 0);
      end
    end
    @(negedge clk);
    check("R2 single pulse", done_o, 0);

    // R7 loop wrap: code 0 always false, low half 0 -> 0xFFFF, branch
    issue(2'd1, 6'h00, 0, 32'h1234_0000, 0, 32'h1000, 32'h0000_FFF0, 0);
    check("R7 count", count_o, 32'h1234_FFFF);
    check("R7 we", count_we_o, 1);
    check("R7 branch", branch_o, 1);
    check("R11 loop target", target_o, 32'h0000_0FF0);
    // R7 no wrap
    issue(2'd1, 6'h01, 32'h0800_0000, 32'hABCD_0005, 0, 0, 0, 0);
    check("R7 count", count_o, 32'hABCD_0004);
    check("R7 no branch", branch_o, 0);
    // R7 wrap with flag-dependent false predicate (0x14: N and not Z, N clear)
    issue(2'd1, 6'h14, 32'h0400_0000, 32'hFFFF_0000, 0, 0, 0, 0);
    check("R7 count wrap", count_o, 32'hFFFF_FFFF);
    check("R7 branch wrap", branch_o, 1);
    // R8 true predicate: no write, no branch
    issue(2'd1, 6'h0F, 0, 32'h0000_0000, 0, 0, 0, 0);
    check("R8 we", count_we_o, 0);
    check("R8 branch", branch_o, 0);
    // R6 illegal loop request
    issue(2'd1, 6'h20, 0, 32'h0000_0000, 0, 0, 0, 0);
    check("R6 loop we", count_we_o, 0);
    check("R6 loop branch", branch_o, 0);

    // R11 conditional branch
    issue(2'd0, 6'h0F, 0, 0, 0, 32'h0000_2000, 32'h1234_FFF0, 0);
    check("R11 taken", branch_o, 1);
    check("R11 short target", target_o, 32'h0000_1FF0);
    issue(2'd0, 6'h0F, 0, 0, 0, 32'h0000_2000, 32'h0000_FFF0, 1);
    check("R11 long target", target_o, 32'h0001_1FF0);
    issue(2'd0, 6'h08, 0, 0, 0, 32'h0000_2000, 32'h10, 0);
    check("R11 not taken", branch_o, 0);
    issue(2'd0, 6'h08, 32'h0100_0000, 0, 0, 32'h0000_2000, 32'h10, 0);
    check("R11 nan taken", branch_o, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule